// File: doc/BRIEF.md
# ECP Extended Control Register and Byte FIFO

This block is the host-side register set of an extended-capability parallel port. Software reaches it over a byte-wide bus with address offsets from the port base. An extended control register selects the operating mode, exposes the FIFO empty and full flags, and carries the service-interrupt, DMA-enable and fault-mask controls. A 16-byte on-chip FIFO holds bytes for the port. It is reached from the bus at the data-FIFO offset. In configuration mode that same offset returns a word-size descriptor instead.

A threshold service mechanism raises an interrupt pulse when the FIFO needs attention. With the direction bit set (reverse, peripheral to host), the condition is a fill level. With the direction bit clear (forward), it is free space. In DMA operation the block instead holds a request line while there is room and stops on a terminal count. A simple take/give strobe pair stands in for the line-side engine.

The test mode lets software push and pop the FIFO directly, so that it can measure depth and thresholds.

Top module: `ecp_ctrl_regs`

## Requirements
- R1: After reset, the extended control register at offset 0x402 reads 0x15. That is mode 000, bit 4 set, bit 2 set and the empty flag set. The control register at offset 0x002 reads 0x00, and dma_req and svc_irq are 0.
- R2: In the extended control register, bit 0 reads 1 exactly when the FIFO is empty and bit 1 reads 1 exactly when it holds 16 bytes. Writes never change either bit.
- R3: Extended control bits 7:5 hold the mode: 000 standard, 001 byte, 010 FIFO, 011 ECP, 110 test, 111 configuration. A write is taken only if the current mode is 000 or 001, the written mode is 000 or 001, or the written mode equals the current one. Any other write is ignored in full.
- R4: In mode 111, a read of offset 0x400 returns 0x10, which is word-size field bits 5:4 = 01 for 8-bit words. A write to 0x400 in that mode leaves the FIFO untouched. Offset 0x401 reads 0x00.
- R5: In modes 010, 011 and 110, a write to 0x400 pushes a byte and a read pops one. Bytes leave in write order, and the empty flag rises only after the last byte has been read.
- R6: A push into a full FIFO is dropped. A pop from an empty FIFO returns 0x00. Neither changes the FIFO contents.
- R7: A taken write whose mode is 000 or 001 empties the FIFO. The control register, including direction bit 5, is unchanged.
- R8: With direction 1, bit 2 clear and DMA disabled, in mode 010, 011 or 110, bit 2 is set in the cycle after the fill count reaches RD_THR (8), and svc_irq pulses for one cycle.
- R9: With direction 0 under the same conditions, bit 2 is set once free space reaches WR_THR (8), again with one svc_irq pulse.
- R10: Once set, bit 2 stays set until software writes 0. While it is 1, threshold events produce no svc_irq pulse.
- R11: dma_req is 1 one cycle after the following all hold: mode 010 or 011, direction 0, DMA enable (bit 3) 1, bit 2 clear, and the FIFO not full.
- R12: A dma_tc pulse while DMA is enabled sets bit 2, pulses svc_irq, and drops dma_req at the same edge.
- R13: In mode 010 or 011, a line_take pulse with direction 0 pops a byte and presents it on line_dout with line_valid the next cycle. A line_give pulse with direction 1 pushes line_din.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset from port base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| line_take | input | 1 | Line engine takes one byte (forward) |
| line_give | input | 1 | Line engine delivers one byte (reverse) |
| line_din | input | 8 | Byte delivered by the line engine |
| line_dout | output | 8 | Byte handed to the line engine |
| line_valid | output | 1 | line_dout holds a fresh byte |
| dma_tc | input | 1 | DMA terminal count |
| dma_req | output | 1 | DMA request |
| svc_irq | output | 1 | One-cycle service interrupt pulse |

## Verification
A seeded random mix of pushes, pops and flag reads in test mode is compared against a queue model. This separates ordering and pointer-wrap faults from flag faults.

Directed fill and drain sequences, probed after every byte, fix the exact count at which the service bit rises in each direction. This separates a read-threshold fault from a write-threshold fault.

Mode-change attempts between two non-plain modes, writes to the status bits, and accesses in configuration mode show which writes are ignored. A DMA run up to full, a line-side take and a terminal count show the request gating.

// File: rtl/ecp_regs_pkg.sv
package ecp_regs_pkg;

  typedef enum logic [2:0] {
    MD_STD  = 3'b000,
    MD_BYTE = 3'b001,
    MD_FIFO = 3'b010,
    MD_ECP  = 3'b011,
    MD_EPP  = 3'b100,
    MD_RSV  = 3'b101,
    MD_TEST = 3'b110,
    MD_CFG  = 3'b111
  } ecp_mode_e;

  localparam int OFS_CTL  = 'h002;
  localparam int OFS_FIFO = 'h400;
  localparam int OFS_CFGB = 'h401;
  localparam int OFS_ECR  = 'h402;

  // word-size field 01 in bits 5:4: 8-bit words
  localparam logic [7:0] CFGA_VAL = 8'h10;

  function automatic logic is_plain(input ecp_mode_e m);
    return (m == MD_STD) || (m == MD_BYTE);
  endfunction

  function automatic logic is_fifo_port(input ecp_mode_e m);
    return (m == MD_FIFO) || (m == MD_ECP) || (m == MD_TEST);
  endfunction

  function automatic logic is_line_mode(input ecp_mode_e m);
    return (m == MD_FIFO) || (m == MD_ECP);
  endfunction

endpackage

// File: rtl/ecp_byte_fifo.sv
module ecp_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

endmodule

// File: rtl/ecp_service.sv
module ecp_service
  import ecp_regs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RD_THR = 8,
  parameter int WR_THR = 8,
  parameter int CW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ecp_mode_e     mode,
  input  logic          dir,
  input  logic          dma_en,
  input  logic          sw_wr,
  input  logic          sw_svc,
  input  logic          dma_tc,
  input  logic [CW-1:0] count,
  input  logic          full,
  output logic          svc,
  output logic          irq,
  output logic          dma_req
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] RTHR_C  = CW'(RD_THR);
  localparam logic [CW-1:0] WTHR_C  = CW'(WR_THR);

  logic [CW-1:0] space;
  logic          thr_hit, hw_set;

  assign space   = DEPTH_C - count;
  assign thr_hit = dir ? (count >= RTHR_C) : (space >= WTHR_C);
  assign hw_set  = !svc && ((is_fifo_port(mode) && !dma_en && thr_hit) ||
                            (dma_en && dma_tc));

  always_ff @(posedge clk) begin
    if (rst) begin
      svc     <= 1'b1;
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (sw_wr) begin
        svc <= sw_svc;
      end else if (hw_set) begin
        svc <= 1'b1;
        irq <= 1'b1;
      end
      dma_req <= is_line_mode(mode) && !dir && dma_en && !svc && !full && !dma_tc;
    end
  end

endmodule

// File: rtl/ecp_ctrl_regs.sv
module ecp_ctrl_regs
  import ecp_regs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 16,
  parameter int RD_THR = 8,
  parameter int WR_THR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              line_take,
  input  logic              line_give,
  input  logic [7:0]        line_din,
  output logic [7:0]        line_dout,
  output logic              line_valid,
  input  logic              dma_tc,
  output logic              dma_req,
  output logic              svc_irq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(OFS_FIFO);
  localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(OFS_CFGB);
  localparam logic [ADDR_W-1:0] A_ECR  = ADDR_W'(OFS_ECR);

  logic [7:0]       ctl_q;
  ecp_mode_e        mode_q, new_mode;
  logic             fmask_q, dmaen_q;
  logic             hit_ctl, hit_fifo, hit_cfgb, hit_ecr;
  logic             ecr_wr_ok, flush, dir;
  logic             bus_push, bus_pop, line_pop, line_push, push, pop;
  logic [7:0]       push_data, head, ecr_val;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_empty, fifo_full, svc;

  assign hit_ctl  = (bus_addr == A_CTL);
  assign hit_fifo = (bus_addr == A_FIFO);
  assign hit_cfgb = (bus_addr == A_CFGB);
  assign hit_ecr  = (bus_addr == A_ECR);

  assign new_mode  = ecp_mode_e'(bus_wdata[7:5]);
  assign ecr_wr_ok = bus_wr && hit_ecr &&
                     (is_plain(mode_q) || is_plain(new_mode) || (new_mode == mode_q));
  assign flush     = ecr_wr_ok && is_plain(new_mode);
  assign dir       = ctl_q[5];

  assign bus_push  = bus_wr && hit_fifo && is_fifo_port(mode_q);
  assign bus_pop   = bus_rd && hit_fifo && is_fifo_port(mode_q);
  assign line_pop  = line_take && is_line_mode(mode_q) && !dir && !bus_pop;
  assign line_push = line_give && is_line_mode(mode_q) && dir && !bus_push;
  assign push      = bus_push || line_push;
  assign pop       = bus_pop || line_pop;
  assign push_data = bus_push ? bus_wdata : line_din;

  assign ecr_val = {mode_q, fmask_q, dmaen_q, svc, fifo_full, fifo_empty};

  ecp_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (push),
    .wdata (push_data),
    .pop   (pop),
    .head  (head),
    .count (fifo_cnt),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  ecp_service #(.DEPTH(DEPTH), .RD_THR(RD_THR), .WR_THR(WR_THR)) u_svc (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .dir     (dir),
    .dma_en  (dmaen_q),
    .sw_wr   (ecr_wr_ok),
    .sw_svc  (bus_wdata[2]),
    .dma_tc  (dma_tc),
    .count   (fifo_cnt),
    .full    (fifo_full),
    .svc     (svc),
    .irq     (svc_irq),
    .dma_req (dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= 8'h00;
      mode_q  <= MD_STD;
      fmask_q <= 1'b1;
      dmaen_q <= 1'b0;
    end else begin
      if (bus_wr && hit_ctl) ctl_q <= bus_wdata;
      if (ecr_wr_ok) begin
        mode_q  <= new_mode;
        fmask_q <= bus_wdata[4];
        dmaen_q <= bus_wdata[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else if (bus_rd) begin
      if (hit_ecr)                         bus_rdata <= ecr_val;
      else if (hit_ctl)                    bus_rdata <= ctl_q;
      else if (hit_fifo && mode_q == MD_CFG) bus_rdata <= CFGA_VAL;
      else if (bus_pop && !fifo_empty)     bus_rdata <= head;
      else if (hit_cfgb)                   bus_rdata <= 8'h00;
      else                                 bus_rdata <= 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_dout  <= 8'h00;
      line_valid <= 1'b0;
    end else begin
      line_valid <= line_pop && !fifo_empty;
      if (line_pop && !fifo_empty) line_dout <= head;
    end
  end

endmodule

// File: rtl/ecp_ctrl_regs_chk.sv
module ecp_ctrl_regs_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] cnt,
  input logic          svc,
  input logic          irq,
  input logic          dma_req,
  input logic          dma_en,
  input logic          dir,
  input logic          push,
  input logic          pop,
  input logic          flush
);

  // R2
  no_full_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (cnt == $past(cnt)));

  // R10
  irq_marks_svc_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> svc);

  // R11
  dma_req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(dma_en && !svc && !dir && !full));

  // R3
  mode_move_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> (($past(mode) <= 3'd1) || (mode <= 3'd1)));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

endmodule

bind ecp_ctrl_regs ecp_ctrl_regs_chk #(.CW(CNT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode_q),
  .full    (fifo_full),
  .empty   (fifo_empty),
  .cnt     (fifo_cnt),
  .svc     (svc),
  .irq     (svc_irq),
  .dma_req (dma_req),
  .dma_en  (dmaen_q),
  .dir     (dir),
  .push    (push),
  .pop     (pop),
  .flush   (flush)
);

// File: tb/test_ecp_ctrl_regs.sv
module test_ecp_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        line_take = 1'b0, line_give = 1'b0;
  logic [7:0]  line_din = '0;
  logic [7:0]  line_dout;
  logic        line_valid, dma_tc = 1'b0, dma_req, svc_irq;

  int checks = 0, fails = 0, irq_cnt = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  ecp_ctrl_regs i_ecp_ctrl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_take(line_take),
    .line_give(line_give), .line_din(line_din), .line_dout(line_dout),
    .line_valid(line_valid), .dma_tc(dma_tc), .dma_req(dma_req), .svc_irq(svc_irq)
  );

  always @(negedge clk) if (!rst && svc_irq) irq_cnt++;

  localparam logic [10:0] CTL = 11'h002, FIFO = 11'h400, CFGB = 11'h401, ECR = 11'h402;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    @(negedge clk);
  endtask

  function automatic logic [7:0] flags_exp(input int n);
    return {6'b0, (n == 16), (n == 0)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(ECR, v); check("R1 ecr", v, 8'h15);
    rd(CTL, v); check("R1 ctl", v, 8'h00);
    check("R1 dma_req", {7'b0, dma_req}, 8'h00);
    check("R1 svc_irq", {7'b0, svc_irq}, 8'h00);

    // R4 configuration window, R3 illegal move
    wr(ECR, 8'h34); wr(ECR, 8'hf4);
    rd(FIFO, v); check("R4 cfgA", v, 8'h10);
    rd(CFGB, v); check("R4 cfgB", v, 8'h00);
    wr(FIFO, 8'hAA);
    rd(ECR, v); check("R4 write ignored", v, 8'hF5);
    wr(ECR, 8'hd4);
    rd(ECR, v); check("R3 cfg->test ignored", v, 8'hF5);
    wr(ECR, 8'h34);
    rd(ECR, v); check("R3 back to byte", v, 8'h35);
    // R2 status bits not writable
    wr(ECR, 8'h36);
    rd(ECR, v); check("R2 status ro", v, 8'h35);

    // R8 read threshold, direction 1
    wr(CTL, 8'h20); wr(ECR, 8'hd4); wr(ECR, 8'hd0);
    base = irq_cnt;
    for (int i = 0; i < 16; i++) begin
      wr(FIFO, 8'(i));
      rd(ECR, v);
      if (i == 6) check("R8 below thr", {7'b0, v[2]}, 8'h00);
      if (i == 7) begin
        check("R8 at thr", {7'b0, v[2]}, 8'h01);
        check("R8 irq", 8'(irq_cnt - base), 8'h01);
      end
    end
    rd(ECR, v); check("R5 full flags", v, 8'hD6);
    wr(FIFO, 8'hEE);  // R6 dropped

    // R9 write threshold, direction 0
    wr(ECR, 8'hd4); wr(CTL, 8'h00); wr(ECR, 8'hd0);
    base = irq_cnt;
    for (int i = 0; i < 16; i++) begin
      rd(FIFO, v); check("R5 order", v, 8'(i));
      rd(ECR, v);
      if (i < 15) check("R5 not empty early", {7'b0, v[0]}, 8'h00);
      if (i == 6) check("R9 below thr", {7'b0, v[2]}, 8'h00);
      if (i == 7) check("R9 at thr", {7'b0, v[2]}, 8'h01);
    end
    rd(ECR, v); check("R5 empty after last", v, 8'hD5);
    // R10 stays set, no further pulses
    check("R10 single irq", 8'(irq_cnt - base), 8'h01);
    rd(FIFO, v); check("R6 empty pop", v, 8'h00);
    rd(ECR, v); check("R6 still empty", v, 8'hD5);

    // R7 flush keeps direction
    wr(ECR, 8'hd4); wr(CTL, 8'h20);
    wr(FIFO, 8'h11); wr(FIFO, 8'h22); wr(FIFO, 8'h33);
    wr(ECR, 8'h34);
    rd(ECR, v); check("R7 flushed", v, 8'h35);
    rd(CTL, v); check("R7 dir kept", v, 8'h20);

    // R5 random test-mode traffic against a queue model
    wr(ECR, 8'hd4);
    q.delete();
    for (int n = 0; n < 300; n++) begin
      int op = $urandom % 3;
      if (op == 0) begin
        logic [7:0] d = 8'($urandom);
        wr(FIFO, d);
        if (q.size() < 16) q.push_back(d);
      end else if (op == 1) begin
        rd(FIFO, v);
        if (q.size() > 0) check("R5 random data", v, q.pop_front());
        else check("R6 random empty", v, 8'h00);
      end else begin
        rd(ECR, v);
        check("R2 random flags", {6'b0, v[1:0]}, flags_exp(q.size()));
      end
    end

    // R11 DMA request gating
    wr(ECR, 8'h34); wr(CTL, 8'h00); wr(ECR, 8'h68);
    check("R11 req on", {7'b0, dma_req}, 8'h01);
    for (int i = 0; i < 16; i++) wr(FIFO, 8'h40 + 8'(i));
    check("R11 req off full", {7'b0, dma_req}, 8'h00);
    // R13 line take
    @(negedge clk); line_take = 1'b1;
    @(negedge clk); line_take = 1'b0;
    check("R13 take valid", {7'b0, line_valid}, 8'h01);
    check("R13 take data", line_dout, 8'h40);
    @(negedge clk);
    check("R11 req back", {7'b0, dma_req}, 8'h01);
    // R12 terminal count
    base = irq_cnt;
    @(negedge clk); dma_tc = 1'b1;
    @(negedge clk); dma_tc = 1'b0;
    check("R12 req drop", {7'b0, dma_req}, 8'h00);
    check("R12 irq", {7'b0, svc_irq}, 8'h01);
    rd(ECR, v); check("R12 svc set", {7'b0, v[2]}, 8'h01);

    // R13 line give, reverse direction
    wr(CTL, 8'h20); wr(ECR, 8'h34); wr(ECR, 8'h74);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); line_give = 1'b1; line_din = 8'hC0 + 8'(i);
      @(negedge clk); line_give = 1'b0;
    end
    for (int i = 0; i < 3; i++) begin
      rd(FIFO, v); check("R13 give order", v, 8'hC0 + 8'(i));
    end
    rd(ECR, v); check("R13 drained", {7'b0, v[0]}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule